// File: doc/BRIEF.md
# Fractional-Increment Real-Time Clock Counter

This block keeps wall time from a slow clock whose nominal rate is 32768 Hz. On each enabled cycle it adds a programmable 24-bit increment to a 32-bit sub-second fraction, where a full 2^32 equals one second. The carry out of the fraction advances a 32-bit seconds count. The six lowest increment bits lie below the fraction's LSB. They build up in a hidden six-bit register, and each overflow of that register adds one extra LSB to the fraction. This allows the rate to be trimmed in steps much finer than one fraction LSB.

The correct increment for a slow clock of frequency f is 2^38 / f. The reset value 0x80_0000 matches an exact 32768 Hz source. Software never writes the active increment directly. It writes a 16-bit low part and an 8-bit high part into staging registers, then pulses a load strobe. The load copies both parts into the active increment together, so a half-written value is never used. A synchronous enable freezes the time counters. Loads still work while the counters are frozen.

Top module: `rtc_frac_counter`

## Requirements
- R1: While rst_ni is low, sec_o and subsec_o are 0, the hidden six-bit remainder is cleared, and the active increment is 0x80_0000.
- R2: With the reset increment, every enabled cycle adds 2^17 to subsec_o, so 32768 enabled cycles give exactly sec_o = 1 and subsec_o = 0.
- R3: On each enabled cycle, increment bits [23:6] are added to subsec_o bits [17:0], and the carry ripples through all 32 bits of subsec_o.
- R4: On each enabled cycle, increment bits [5:0] are added to the hidden six-bit remainder. A carry out of that sum adds one more LSB to subsec_o in the same cycle.
- R5: A carry out of bit 31 of subsec_o adds one to sec_o in the same cycle. sec_o wraps modulo 2^32 and raises no flag.
- R6: inc_o bits [23:0] show the active increment, and bits [31:24] always read zero.
- R7: Writes to the staging parts (inc_lo_i with inc_lo_we_i, inc_hi_i with inc_hi_we_i) do not change inc_o or the counting until a load occurs.
- R8: A one-cycle pulse on inc_load_i copies the staged {high, low} value into the active increment at that clock edge. The accumulation in that same edge still uses the previous increment.
- R9: While cnt_en_i is low, sec_o, subsec_o and the hidden remainder hold their values, and staging writes and loads still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable; low freezes time |
| inc_lo_i | input | 16 | Staged increment bits [15:0] |
| inc_lo_we_i | input | 1 | Write strobe for the low staging part |
| inc_hi_i | input | 8 | Staged increment bits [23:16] |
| inc_hi_we_i | input | 1 | Write strobe for the high staging part |
| inc_load_i | input | 1 | Copies the staged value into the active increment |
| sec_o | output | 32 | Seconds count |
| subsec_o | output | 32 | Sub-second fraction, 2^32 = one second |
| inc_o | output | 32 | Active increment, upper byte zero |

## Verification
The hidden remainder cannot be observed directly. If it holds a wrong value, subsec_o shows one extra LSB, or one LSB too few, within at most 64 enabled cycles. The bench therefore runs small-remainder increments across the overflow boundary, and it repeats a run after a reset part way through it. An error in the alignment or carry chain moves subsec_o on the very next enabled cycle. A lost carry out of the fraction shows up at the exact cycle of a second boundary. A staging fault appears on inc_o one cycle after a write or a load.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned INC_W    = 24;
  localparam int unsigned FRAC_W   = 6;
  localparam int unsigned SUB_W    = 32;
  localparam int unsigned SEC_W    = 32;
  localparam int unsigned LO_W     = 16;
  localparam int unsigned REG_W    = 32;
  localparam logic [INC_W-1:0] INC_RESET = 24'h80_0000;
endpackage

// File: rtl/rtc_inc_stage.sv
module rtc_inc_stage #(
  parameter int unsigned INC_W = rtc_pkg::INC_W,
  parameter int unsigned LO_W  = rtc_pkg::LO_W,
  parameter logic [INC_W-1:0] INC_RESET = rtc_pkg::INC_RESET
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LO_W-1:0]       lo_i,
  input  logic                  lo_we_i,
  input  logic [INC_W-LO_W-1:0] hi_i,
  input  logic                  hi_we_i,
  input  logic                  load_i,
  output logic [INC_W-1:0]      inc_o
);
  localparam int unsigned HI_W = INC_W - LO_W;

  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [INC_W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= INC_RESET[LO_W-1:0];
      hi_q <= INC_RESET[INC_W-1:LO_W];
    end else begin
      if (lo_we_i) lo_q <= lo_i;
      if (hi_we_i) hi_q <= hi_i;
    end
  end

  // commit uses staged contents as held before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= INC_RESET;
    else if (load_i) act_q <= {hi_q, lo_q};
  end

  assign inc_o = act_q;
endmodule

// File: rtl/rtc_sub_acc.sv
module rtc_sub_acc #(
  parameter int unsigned INC_W  = rtc_pkg::INC_W,
  parameter int unsigned FRAC_W = rtc_pkg::FRAC_W,
  parameter int unsigned SUB_W  = rtc_pkg::SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [SUB_W-1:0] sub_o,
  output logic             carry_o
);
  localparam int unsigned WHOLE_W = INC_W - FRAC_W;

  logic [FRAC_W-1:0] frac_q;
  logic [SUB_W-1:0]  sub_q;
  logic [FRAC_W:0]   frac_sum;
  logic [SUB_W:0]    sub_sum;

  assign frac_sum = {1'b0, frac_q} + {1'b0, inc_i[FRAC_W-1:0]};
  assign sub_sum  = {1'b0, sub_q}
                  + {{(SUB_W-WHOLE_W+1){1'b0}}, inc_i[INC_W-1:FRAC_W]}
                  + {{SUB_W{1'b0}}, frac_sum[FRAC_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      sub_q  <= '0;
    end else if (en_i) begin
      frac_q <= frac_sum[FRAC_W-1:0];
      sub_q  <= sub_sum[SUB_W-1:0];
    end
  end

  assign sub_o   = sub_q;
  assign carry_o = en_i & sub_sum[SUB_W];
endmodule

// File: rtl/rtc_sec_cnt.sv
module rtc_sec_cnt #(
  parameter int unsigned SEC_W = rtc_pkg::SEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sec_q <= '0;
    else if (step_i) sec_q <= sec_q + 1'b1;
  end

  assign sec_o = sec_q;
endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter #(
  parameter int unsigned INC_W  = rtc_pkg::INC_W,
  parameter int unsigned FRAC_W = rtc_pkg::FRAC_W,
  parameter int unsigned SUB_W  = rtc_pkg::SUB_W,
  parameter int unsigned SEC_W  = rtc_pkg::SEC_W,
  parameter int unsigned LO_W   = rtc_pkg::LO_W,
  parameter int unsigned REG_W  = rtc_pkg::REG_W,
  parameter logic [INC_W-1:0] INC_RESET = rtc_pkg::INC_RESET
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cnt_en_i,
  input  logic [LO_W-1:0]       inc_lo_i,
  input  logic                  inc_lo_we_i,
  input  logic [INC_W-LO_W-1:0] inc_hi_i,
  input  logic                  inc_hi_we_i,
  input  logic                  inc_load_i,
  output logic [SEC_W-1:0]      sec_o,
  output logic [SUB_W-1:0]      subsec_o,
  output logic [REG_W-1:0]      inc_o
);
  logic [INC_W-1:0] inc_act;
  logic             sub_carry;

  rtc_inc_stage #(.INC_W(INC_W), .LO_W(LO_W), .INC_RESET(INC_RESET)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_i    (inc_lo_i),
    .lo_we_i (inc_lo_we_i),
    .hi_i    (inc_hi_i),
    .hi_we_i (inc_hi_we_i),
    .load_i  (inc_load_i),
    .inc_o   (inc_act)
  );

  rtc_sub_acc #(.INC_W(INC_W), .FRAC_W(FRAC_W), .SUB_W(SUB_W)) u_sub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en_i),
    .inc_i   (inc_act),
    .sub_o   (subsec_o),
    .carry_o (sub_carry)
  );

  rtc_sec_cnt #(.SEC_W(SEC_W)) u_sec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (sub_carry),
    .sec_o  (sec_o)
  );

  generate
    if (REG_W > INC_W) begin : g_pad
      assign inc_o = {{(REG_W-INC_W){1'b0}}, inc_act};
    end else begin : g_nopad
      assign inc_o = inc_act[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/rtc_frac_counter_chk.sv
module rtc_frac_counter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cnt_en_i,
  input logic        inc_load_i,
  input logic [31:0] sec_o,
  input logic [31:0] subsec_o,
  input logic [31:0] inc_o
);
  p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o[31:24] == 8'h00);

  p_hold_no_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_load_i |=> $stable(inc_o));

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> ($stable(sec_o) && $stable(subsec_o)));

  p_sub_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |=> ((subsec_o - $past(subsec_o) - {14'h0, $past(inc_o[23:6])}) <= 32'd1));

  p_sec_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |=> ((sec_o != $past(sec_o)) == (subsec_o < $past(subsec_o))));

  p_sec_plus_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |=> (sec_o - $past(sec_o)) <= 32'd1);
endmodule

bind rtc_frac_counter rtc_frac_counter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_en_i   (cnt_en_i),
  .inc_load_i (inc_load_i),
  .sec_o      (sec_o),
  .subsec_o   (subsec_o),
  .inc_o      (inc_o)
);

// File: tb/tb_rtc_frac_counter.sv
module tb_rtc_frac_counter;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] inc;
    logic [31:0] cyc;
    logic [31:0] sec;
    logic [31:0] sub;
  } vec_t;

  // R2 R3 R4 R5 expectations: floor(cyc * inc / 64) split into sec:sub
  localparam vec_t VECS [6] = '{
    '{24'h80_0000, 32'd32768, 32'd1, 32'h0000_0000},
    '{24'h80_0000, 32'd32769, 32'd1, 32'h0002_0000},
    '{24'h00_0001, 32'd64,    32'd0, 32'h0000_0001},
    '{24'h00_003F, 32'd10,    32'd0, 32'h0000_0009},
    '{24'h80_0001, 32'd64,    32'd0, 32'h0080_0001},
    '{24'hFF_FFFF, 32'd16385, 32'd1, 32'h0003_FEFF}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic [15:0] inc_lo_i = '0;
  logic        inc_lo_we_i = 1'b0;
  logic [7:0]  inc_hi_i = '0;
  logic        inc_hi_we_i = 1'b0;
  logic        inc_load_i = 1'b0;
  logic [31:0] sec_o, subsec_o, inc_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_frac_counter dut (
    .clk_i, .rst_ni, .cnt_en_i, .inc_lo_i, .inc_lo_we_i, .inc_hi_i,
    .inc_hi_we_i, .inc_load_i, .sec_o, .subsec_o, .inc_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cnt_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic stage_load(input logic [23:0] v);
    @(negedge clk_i);
    inc_lo_i = v[15:0]; inc_hi_i = v[23:16];
    inc_lo_we_i = 1'b1; inc_hi_we_i = 1'b1;
    @(negedge clk_i);
    inc_lo_we_i = 1'b0; inc_hi_we_i = 1'b0;
    inc_load_i = 1'b1;
    @(negedge clk_i);
    inc_load_i = 1'b0;
  endtask

  task automatic run(input int n);
    cnt_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cnt_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    check("R1 sec reset", sec_o, 32'h0);
    check("R1 sub reset", subsec_o, 32'h0);
    check("R6 inc reset", inc_o, 32'h0080_0000);
    rst_ni = 1'b1;

    for (int i = 0; i < 6; i++) begin
      do_reset();
      stage_load(VECS[i].inc);
      check("R6 inc loaded", inc_o, {8'h00, VECS[i].inc});
      run(int'(VECS[i].cyc));
      check("R5 vector sec", sec_o, VECS[i].sec);
      check("R3 R4 vector sub", subsec_o, VECS[i].sub);
    end

    // R7: staging writes without load
    do_reset();
    @(negedge clk_i);
    inc_lo_i = 16'h1234; inc_hi_i = 8'h56;
    inc_lo_we_i = 1'b1; inc_hi_we_i = 1'b1;
    @(negedge clk_i);
    inc_lo_we_i = 1'b0; inc_hi_we_i = 1'b0;
    check("R7 inc unchanged", inc_o, 32'h0080_0000);
    run(1);
    check("R7 default still used", subsec_o, 32'h0002_0000);

    // R8: commit, same-edge accumulation uses old value
    inc_load_i = 1'b1; cnt_en_i = 1'b1;
    @(negedge clk_i);
    inc_load_i = 1'b0; cnt_en_i = 1'b0;
    check("R8 inc committed", inc_o, 32'h0056_1234);
    check("R8 old inc at load edge", subsec_o, 32'h0004_0000);
    run(1);
    check("R8 new inc used", subsec_o, 32'h0005_5848);
    run(1);
    check("R4 remainder carry", subsec_o, 32'h0006_B091);

    // R9: freeze, loads accepted while frozen
    repeat (50) @(negedge clk_i);
    check("R9 sub frozen", subsec_o, 32'h0006_B091);
    check("R9 sec frozen", sec_o, 32'h0);
    stage_load(24'h80_0000);
    check("R9 load while frozen", inc_o, 32'h0080_0000);
    check("R9 sub still frozen", subsec_o, 32'h0006_B091);
    run(1);
    check("R9 resume", subsec_o, 32'h0008_B091);

    // R1: reset clears the hidden remainder
    do_reset();
    stage_load(24'h00_0001);
    run(40);
    check("R1 partial remainder", subsec_o, 32'h0);
    do_reset();
    check("R1 inc back to default", inc_o, 32'h0080_0000);
    stage_load(24'h00_0001);
    run(63);
    check("R1 remainder cleared", subsec_o, 32'h0);
    run(1);
    check("R4 overflow at 64", subsec_o, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule